// File: doc/BRIEF.md
# Programmable Bus Chip-Select Decoder

This block turns the control strobes and address of an 8-bit-style bus into three active-low chip selects: one for external I/O devices, one for an external RAM array and one for an external ROM array. The selects are pure combinational decodes of the bus, so they follow any bus master, whether the local processor or an external one. The same decode applies in both cases.

A small configuration register file sets where the selects fall. It is loaded through a one-cycle write port. RAM and ROM each get an inclusive window of 4 KB banks, taken from the top address bits. The ROM window starts above an optional on-chip ROM. The I/O select stays clear of a 64-register on-chip block that can be moved within the low address byte. It also stays clear of a fixed internal window. A mode bit chooses between decoding the on-chip ranges only by the low byte and decoding them by the full 16-bit I/O address.

Top module: `bus_csel`

## Requirements
- R1: `io_cs_n` is low only while `iorq_n` is low and `m1_n` is high, so interrupt-acknowledge cycles never assert it.
- R2: With the high-I/O bit cleared, an I/O cycle asserts `io_cs_n` unless one of two conditions holds. The low byte lies in 0xD8–0xF7 on any page, or the low byte lies inside the on-chip block while address bits 15:8 are zero.
- R3: With the high-I/O bit set, an I/O cycle asserts `io_cs_n` unless address bits 15:8 are zero and the low byte lies inside the on-chip block or inside 0xD8–0xF7.
- R4: The relocation field places the 64-register on-chip block at low-byte base 0x00, 0x40, 0x80 or 0xC0 for field values 0 to 3. The 0xD8–0xF7 window does not move.
- R5: `ram_cs_n` is low exactly when `mreq_n` is low, `rfsh_n` is high and addr[19:12] lies in [RAM lower bound, RAM upper bound], bounds included.
- R6: `rom_cs_n` is low exactly when `mreq_n` is low, `rfsh_n` is high and addr[19:12] lies in [base, ROM bound], bounds included. The base is the on-chip ROM top value when on-chip ROM is enabled and zero otherwise.
- R7: A refresh cycle (`rfsh_n` low) never asserts `ram_cs_n` or `rom_cs_n`. An I/O cycle without `mreq_n` low asserts neither.
- R8: Reset gives the following register values. RAM lower bound 0xFF, RAM upper bound 0x00, ROM bound 0xFF, on-chip ROM top 0x00, relocation 0, high-I/O decode 0, on-chip ROM disabled.
- R9: The write index selects the register as follows. Index 0 is the RAM lower bound, 1 the RAM upper bound, 2 the ROM bound and 4 the on-chip ROM top. Index 3 is the control byte, with bits 1:0 holding relocation, bit 2 high-I/O decode and bit 3 on-chip ROM enable. Writes to indices 5–7 change nothing.
- R10: A write presented with `cfg_we` high changes the selects only after the next rising clock edge. Before that edge the selects follow the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| iorq_n | input | 1 | I/O request strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| m1_n | input | 1 | Opcode-fetch / acknowledge marker, active low |
| rfsh_n | input | 1 | Refresh cycle marker, active low |
| addr | input | 20 | Bus address |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | 3 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| io_cs_n | output | 1 | External I/O chip select, active low |
| ram_cs_n | output | 1 | External RAM chip select, active low |
| rom_cs_n | output | 1 | External ROM chip select, active low |

## Verification
The bench builds the block with its defaults: a 20-bit address, 8-bit bank bounds, 16-bit I/O decode and a 2-bit relocation field. With these values the whole low byte can be swept for all eight mode and relocation pairs on pages 0x00, 0x01, 0x80 and 0xFF. All 256 memory banks can be swept for each window setting. This covers every edge of each exclusion window and both inclusive bound edges. It also covers single-bank and empty windows, and a ROM base that switches between the top value and zero.

// File: rtl/csel_pkg.sv
package csel_pkg;
   localparam int unsigned CSEL_BANK_W  = 8;
   localparam int unsigned CSEL_RELOC_W = 2;

   typedef struct packed {
      logic [CSEL_BANK_W-1:0]  ram_lo;
      logic [CSEL_BANK_W-1:0]  ram_up;
      logic [CSEL_BANK_W-1:0]  rom_bound;
      logic [CSEL_BANK_W-1:0]  rom_top;
      logic [CSEL_RELOC_W-1:0] reloc;
      logic                    hio;
      logic                    rom_en;
   } csel_cfg_t;

   localparam logic [2:0] IDX_RAM_LO = 3'd0;
   localparam logic [2:0] IDX_RAM_UP = 3'd1;
   localparam logic [2:0] IDX_ROM_BD = 3'd2;
   localparam logic [2:0] IDX_CTRL   = 3'd3;
   localparam logic [2:0] IDX_ROM_TP = 3'd4;
endpackage

// File: rtl/csel_cfg_regs.sv
module csel_cfg_regs
   import csel_pkg::*;
(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [2:0]             idx,
   input  logic [CSEL_BANK_W-1:0] wdata,
   output csel_cfg_t              cfg
);
   localparam int unsigned CTRL_HIO = CSEL_RELOC_W;
   localparam int unsigned CTRL_REN = CSEL_RELOC_W + 1;

   initial begin
      if (CTRL_REN >= CSEL_BANK_W) $error("control byte too narrow for fields");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.ram_lo    <= '1;
         cfg.ram_up    <= '0;
         cfg.rom_bound <= '1;
         cfg.rom_top   <= '0;
         cfg.reloc     <= '0;
         cfg.hio       <= 1'b0;
         cfg.rom_en    <= 1'b0;
      end else if (we) begin
         case (idx)
            IDX_RAM_LO: cfg.ram_lo    <= wdata;
            IDX_RAM_UP: cfg.ram_up    <= wdata;
            IDX_ROM_BD: cfg.rom_bound <= wdata;
            IDX_ROM_TP: cfg.rom_top   <= wdata;
            IDX_CTRL: begin
               cfg.reloc  <= wdata[CSEL_RELOC_W-1:0];
               cfg.hio    <= wdata[CTRL_HIO];
               cfg.rom_en <= wdata[CTRL_REN];
            end
            default: ;
         endcase
      end
   end

   // R9: without a write the configuration holds
   a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(cfg));

   // R10: a bound write lands at the following edge
   a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (we && idx == IDX_ROM_BD) |=> cfg.rom_bound == $past(wdata));
endmodule

// File: rtl/csel_io_decode.sv
module csel_io_decode #(
   parameter int unsigned IO_W    = 16,
   parameter int unsigned RELOC_W = 2,
   parameter logic [7:0]  FIX_LO  = 8'hD8,
   parameter logic [7:0]  FIX_HI  = 8'hF7
) (
   input  logic [IO_W-1:0]    io_addr,
   input  logic [RELOC_W-1:0] reloc,
   input  logic               hio,
   output logic               hit
);
   localparam int unsigned BLK_SHIFT = 8 - RELOC_W;

   initial begin
      if (IO_W < 8)                       $error("IO_W below 8");
      if (RELOC_W < 1 || RELOC_W > 4)     $error("RELOC_W out of range");
      if (FIX_LO[2:0] != 3'd0)            $error("fixed window must start 8-aligned");
      if (FIX_HI[2:0] != 3'd7)            $error("fixed window must end 8-aligned");
      if (FIX_LO > FIX_HI)                $error("fixed window reversed");
   end

   logic [7:0] lo_byte;
   logic       page_zero;
   logic       in_block;
   logic       in_fixed;

   assign lo_byte = io_addr[7:0];

   generate
      if (IO_W > 8) begin : g_wide
         assign page_zero = ~|io_addr[IO_W-1:8];
      end else begin : g_narrow
         assign page_zero = 1'b1;
      end
   endgenerate

   assign in_block = (lo_byte[7 -: RELOC_W] == reloc);
   assign in_fixed = (lo_byte >= FIX_LO) && (lo_byte <= FIX_HI);

   always_comb begin
      if (hio) hit = !(page_zero && (in_block || in_fixed));
      else     hit = !(in_fixed || (in_block && page_zero));
   end

   logic unused_shift;
   assign unused_shift = (BLK_SHIFT == 0);
endmodule

// File: rtl/csel_mem_window.sv
module csel_mem_window #(
   parameter int unsigned BANK_W = 8
) (
   input  logic [BANK_W-1:0] bank,
   input  logic [BANK_W-1:0] lo,
   input  logic [BANK_W-1:0] hi,
   output logic              hit
);
   initial begin
      if (BANK_W < 1) $error("BANK_W must be positive");
   end

   assign hit = (bank >= lo) && (bank <= hi);
endmodule

// File: rtl/bus_csel.sv
module bus_csel
   import csel_pkg::*;
#(
   parameter int unsigned ADDR_W = 20,
   parameter int unsigned IO_W   = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   iorq_n,
   input  logic                   mreq_n,
   input  logic                   m1_n,
   input  logic                   rfsh_n,
   input  logic [ADDR_W-1:0]      addr,
   input  logic                   cfg_we,
   input  logic [2:0]             cfg_idx,
   input  logic [CSEL_BANK_W-1:0] cfg_wdata,
   output logic                   io_cs_n,
   output logic                   ram_cs_n,
   output logic                   rom_cs_n
);
   localparam int unsigned BANK_LSB = ADDR_W - CSEL_BANK_W;

   initial begin
      if (IO_W > ADDR_W)        $error("IO_W exceeds ADDR_W");
      if (ADDR_W < CSEL_BANK_W) $error("ADDR_W below bank width");
   end

   csel_cfg_t              cfg;
   logic [CSEL_BANK_W-1:0] bank;
   logic [CSEL_BANK_W-1:0] rom_base;
   logic                   io_hit, ram_hit, rom_hit;
   logic                   io_cyc, mem_cyc;

   csel_cfg_regs u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .idx   (cfg_idx),
      .wdata (cfg_wdata),
      .cfg   (cfg)
   );

   csel_io_decode #(.IO_W(IO_W), .RELOC_W(CSEL_RELOC_W)) u_io (
      .io_addr (addr[IO_W-1:0]),
      .reloc   (cfg.reloc),
      .hio     (cfg.hio),
      .hit     (io_hit)
   );

   assign bank     = addr[ADDR_W-1:BANK_LSB];
   assign rom_base = cfg.rom_en ? cfg.rom_top : '0;

   csel_mem_window #(.BANK_W(CSEL_BANK_W)) u_ram (
      .bank (bank), .lo (cfg.ram_lo), .hi (cfg.ram_up), .hit (ram_hit)
   );

   csel_mem_window #(.BANK_W(CSEL_BANK_W)) u_rom (
      .bank (bank), .lo (rom_base), .hi (cfg.rom_bound), .hit (rom_hit)
   );

   assign io_cyc  = !iorq_n && m1_n;
   assign mem_cyc = !mreq_n && rfsh_n;

   assign io_cs_n  = !(io_cyc && io_hit);
   assign ram_cs_n = !(mem_cyc && ram_hit);
   assign rom_cs_n = !(mem_cyc && rom_hit);

   // R1: I/O select only in a non-acknowledge I/O cycle
   a_r1_io_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      !io_cs_n |-> (!iorq_n && m1_n));

   // R7: refresh never selects memory
   a_r7_no_refresh_select: assert property (@(posedge clk) disable iff (!rst_n)
      !rfsh_n |-> (ram_cs_n && rom_cs_n));

   // R2: the fixed internal window on page zero is never selected
   a_r2_fixed_window_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (addr[IO_W-1:0] >= IO_W'(16'h00D8) && addr[IO_W-1:0] <= IO_W'(16'h00F7)) |-> io_cs_n);

   // R5: RAM select implies a memory request
   a_r5_ram_needs_mreq: assert property (@(posedge clk) disable iff (!rst_n)
      !ram_cs_n |-> !mreq_n);
endmodule

// File: tb/bus_csel_bench.sv
module bus_csel_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iorq_n = 1'b1, mreq_n = 1'b1, m1_n = 1'b1, rfsh_n = 1'b1;
   logic [19:0] addr = '0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        io_cs_n, ram_cs_n, rom_cs_n;

   int checks = 0, failures = 0;
   int cycles = 0;
   bit done = 0;

   // model state
   logic [7:0] m_lo = 8'hFF, m_up = 8'h00, m_rb = 8'hFF, m_rt = 8'h00;
   logic [1:0] m_rel = 2'd0;
   logic       m_hio = 1'b0, m_ren = 1'b0;

   always #4 clk = ~clk;

   bus_csel u_bus_csel (
      .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .mreq_n(mreq_n), .m1_n(m1_n),
      .rfsh_n(rfsh_n), .addr(addr), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .io_cs_n(io_cs_n), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         done = 1;
         failures++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s addr=%05h: actual=%b expected=%b", req, addr, act, exp);
      end
   endtask

   function automatic logic exp_io_n(input logic [15:0] a);
      logic pz, blk, fix, hit;
      pz  = (a[15:8] == 8'h00);
      blk = (a[7:6] == m_rel);                  // R4: base = reloc * 0x40
      fix = (a[7:0] >= 8'hD8) && (a[7:0] <= 8'hF7);
      if (m_hio) hit = !(pz && (blk || fix));
      else       hit = !(fix || (blk && pz));
      return !hit;
   endfunction

   function automatic logic exp_ram_n(input logic [7:0] b);
      return !((b >= m_lo) && (b <= m_up));
   endfunction

   function automatic logic exp_rom_n(input logic [7:0] b);
      logic [7:0] base;
      base = m_ren ? m_rt : 8'h00;
      return !((b >= base) && (b <= m_rb));
   endfunction

   task automatic wr(input logic [2:0] idx, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (idx)
         3'd0: m_lo = d;
         3'd1: m_up = d;
         3'd2: m_rb = d;
         3'd3: begin m_rel = d[1:0]; m_hio = d[2]; m_ren = d[3]; end
         3'd4: m_rt = d;
         default: ;
      endcase
   endtask

   task automatic idle();
      iorq_n = 1'b1; mreq_n = 1'b1; m1_n = 1'b1; rfsh_n = 1'b1;
   endtask

   task automatic sweep_io(input string req);
      logic [7:0] pages [4] = '{8'h00, 8'h01, 8'h80, 8'hFF};
      idle();
      iorq_n = 1'b0;
      for (int p = 0; p < 4; p++) begin
         for (int l = 0; l < 256; l++) begin
            addr = {4'h3, pages[p], 8'(l)};
            #1;
            chk(req, io_cs_n, exp_io_n(addr[15:0]));
         end
      end
      idle();
   endtask

   task automatic sweep_mem(input string req);
      idle();
      mreq_n = 1'b0;
      for (int b = 0; b < 256; b++) begin
         addr = {8'(b), 12'(b * 37)};
         #1;
         chk({req, " R5 ram"}, ram_cs_n, exp_ram_n(8'(b)));
         chk({req, " R6 rom"}, rom_cs_n, exp_rom_n(8'(b)));
      end
      rfsh_n = 1'b0;   // R7 refresh
      for (int b = 0; b < 256; b += 5) begin
         addr = {8'(b), 12'h0};
         #1;
         chk("R7 refresh ram", ram_cs_n, 1'b1);
         chk("R7 refresh rom", rom_cs_n, 1'b1);
      end
      idle();
      iorq_n = 1'b0;   // R7 I/O cycle does not select memory
      for (int b = 0; b < 256; b += 7) begin
         addr = {8'(b), 12'h0};
         #1;
         chk("R7 io ram", ram_cs_n, 1'b1);
         chk("R7 io rom", rom_cs_n, 1'b1);
      end
      idle();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R8 reset state: RAM window empty, ROM covers all, I/O default map
      sweep_mem("R8 reset");
      sweep_io("R8 R2 reset io");

      // R1: acknowledge cycle and idle bus never select I/O
      for (int l = 0; l < 256; l += 3) begin
         addr = {4'h0, 8'h12, 8'(l)};
         iorq_n = 1'b0; m1_n = 1'b0; #1;
         chk("R1 ack", io_cs_n, 1'b1);
         iorq_n = 1'b1; m1_n = 1'b1; #1;
         chk("R1 idle", io_cs_n, 1'b1);
      end
      idle();

      // R2 R3 R4: every relocation in both modes
      for (int h = 0; h < 2; h++) begin
         for (int r = 0; r < 4; r++) begin
            wr(3'd3, 8'((h << 2) | r));
            sweep_io(h ? "R3 R4 hio" : "R2 R4 lo");
         end
      end

      // R5 R6: RAM 0x10..0x3F, ROM disabled base, bound 0x7F
      wr(3'd0, 8'h10); wr(3'd1, 8'h3F); wr(3'd2, 8'h7F); wr(3'd4, 8'h08);
      wr(3'd3, 8'h00);
      sweep_mem("R6 rom off");
      wr(3'd3, 8'h08);   // R9 bit3 enables on-chip ROM base
      sweep_mem("R6 rom on");
      // single bank windows
      wr(3'd0, 8'hA5); wr(3'd1, 8'hA5); wr(3'd4, 8'hC0); wr(3'd2, 8'hC0);
      sweep_mem("R5 single");
      // empty: lower above upper
      wr(3'd0, 8'h50); wr(3'd1, 8'h4F);
      sweep_mem("R5 empty");

      // R9: writes to indices 5..7 change nothing
      wr(3'd5, 8'h00); wr(3'd6, 8'hFF); wr(3'd7, 8'h0C);
      sweep_mem("R9 ignored");
      sweep_io("R9 ignored io");

      // R10: effect only after the edge
      idle(); mreq_n = 1'b0; addr = {8'h60, 12'h0};
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'd1; cfg_wdata = 8'h70;
      #1;
      chk("R10 before edge", ram_cs_n, 1'b1);
      cfg_idx = 3'd0; cfg_wdata = 8'h60;   // still before the edge
      @(posedge clk); #1;
      chk("R10 after lo write", ram_cs_n, 1'b1);  // upper still 0x4F
      cfg_idx = 3'd1; cfg_wdata = 8'h70;
      #1;
      chk("R10 pending upper", ram_cs_n, 1'b1);
      @(posedge clk); #1;
      cfg_we = 1'b0;
      chk("R10 upper landed", ram_cs_n, 1'b0);
      idle();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule